// File: doc/BRIEF.md
# Three-wire serial EEPROM slave model

This block is a clock-synchronous behavioural model of a 1024-bit serial EEPROM that answers on a Microwire-style slave port. The port has a select, a serial clock, a serial data input and a serial data output with a separate output-enable flag, so the output can be treated as tri-state. A host raises select and shifts in a frame, one bit per serial-clock rising edge: a start bit, an opcode and an address, plus a data field for the two store commands. The block is used as a stand-in for the memory in a larger design or as the target of a host controller under test.

The serial clock is oversampled by the system clock and only its rising edges count. A strap pin, taken while reset is held, chooses between sixteen-bit words with a six-bit address and bytes with a seven-bit address over the same storage. A store starts a self-timed busy period when select falls. While that period runs, raising select turns the data output into a ready/busy flag. Every other frame is ignored until the period ends.

Top module: `uwire_eeprom`

## Requirements
- R1: While reset is low the strap is sampled (1 = sixteen-bit words, 0 = bytes). Every storage bit is set to 1, writing is locked, there is no busy period, and sdo_oe_o is 0.
- R2: Bits are taken on rising serial-clock edges while select is high. Zeros before the first 1 are skipped. That 1 is the start bit. Next come a 2-bit opcode and the address, most significant bit first. The opcodes are 10 read, 01 write, 11 erase and 00 special.
- R3: A read drives sdo_oe_o high on the edge that takes the last address bit and outputs a 0. Each of the next edges outputs one data bit, most significant first. The edge after the last data bit drops sdo_oe_o. sdo_oe_o is low one clock after select is low.
- R4: While writing is locked, write, erase, erase-all and write-all change no storage and start no busy period.
- R5: In the special group the two most significant address bits pick the command: 11 unlocks writing, 00 locks it, 10 is erase-all and 01 is write-all. Unlocking lasts until a lock command or a reset.
- R6: A write replaces the addressed word with the data field. The change happens only if the whole frame was received before select falls.
- R7: An erase sets the addressed word (or byte) to all ones.
- R8: Erase-all sets the whole store to ones. Write-all copies its data field into every word or byte. Both are busy for BUSY_LONG clock cycles.
- R9: A write or erase is busy for BUSY_SHORT clock cycles, counted from the clock edge that sees select low. If select rises during that period, the data output is enabled and shows 0 while busy and 1 once ready.
- R10: While the status flag is shown and the device is ready, a rising edge with data-in 1 drops sdo_oe_o on that edge. The same bit sent while still busy has no effect.
- R11: Frames that start while a busy period is running are ignored completely.
- R12: In byte organization the address is 7 bits and the data 8 bits. Address bit 0 picks the byte in the stored word (1 = upper byte), and the other byte is not changed.
- R13: Reads work whether writing is locked or unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial port |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_org_i | input | 1 | Organization strap, taken during reset: 1 sixteen-bit, 0 bytes |
| sel_i | input | 1 | Slave select, active high |
| sclk_i | input | 1 | Serial clock; rising edges are active |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, meaningful while sdo_oe_o is high |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |

## Verification
Words with different high and low halves are written and read back, which shows that bit order and the single leading zero are right. Neighbouring addresses are read as well, so a decode slip shows up. Frames with leading zeros, frames cut short, and frames sent while locked show apart a frame that is accepted from one that is dropped. The status flag is checked at a cycle count that falls between the short and the long busy period, so the two busy lengths can be told apart. The same stores are then repeated on neighbouring byte addresses in byte mode to show that only the chosen byte changes.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

   typedef enum logic [1:0] {
      OPC_SPECIAL = 2'b00,
      OPC_WRITE   = 2'b01,
      OPC_READ    = 2'b10,
      OPC_ERASE   = 2'b11
   } uw_opc_e;

   typedef enum logic [1:0] {
      SUB_LOCK    = 2'b00,
      SUB_FILLALL = 2'b01,
      SUB_CLRALL  = 2'b10,
      SUB_UNLOCK  = 2'b11
   } uw_sub_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_WRITE,
      OP_ERASE,
      OP_CLRALL,
      OP_FILLALL
   } uw_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADR,
      ST_DATA,
      ST_READ,
      ST_DONE
   } uw_st_e;

endpackage

// File: rtl/uwire_busy_timer.sv
module uwire_busy_timer #(
   parameter int BUSY_SHORT = 4000,
   parameter int BUSY_LONG  = 8000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic long_i,
   output logic busy_o
);
   localparam int CW = $clog2(BUSY_LONG + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (start_i) begin
         left_q <= long_i ? CW'(BUSY_LONG) : CW'(BUSY_SHORT);
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign busy_o = (left_q != '0);

   // R9: an idle timer stays idle unless started
   assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> !busy_o);

endmodule

// File: rtl/uwire_store.sv
module uwire_store
   import uwire_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_i,
   input  logic              commit_i,
   input  uw_op_e            op_i,
   input  logic [ADDR_W:0]   wr_addr_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic [ADDR_W:0]   rd_addr_i,
   output logic [WORD_W-1:0] rd_data_o
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int BYTE_W = WORD_W / 2;
   localparam int LANES  = 2;

   logic [ADDR_W-1:0] wr_idx, rd_idx;
   logic              bulk;
   logic [LANES-1:0]  lane_mask;
   logic [WORD_W-1:0] wr_val;
   logic [WORD_W-1:0] words [DEPTH];
   logic [WORD_W-1:0] rd_word;

   assign wr_idx = wide_i ? wr_addr_i[ADDR_W-1:0] : wr_addr_i[ADDR_W:1];
   assign rd_idx = wide_i ? rd_addr_i[ADDR_W-1:0] : rd_addr_i[ADDR_W:1];
   assign bulk   = (op_i == OP_CLRALL) || (op_i == OP_FILLALL);

   always_comb begin
      if (bulk || wide_i) lane_mask = '1;
      else                lane_mask = wr_addr_i[0] ? 2'b10 : 2'b01;
      if (op_i == OP_ERASE || op_i == OP_CLRALL) wr_val = '1;
      else if (wide_i)                           wr_val = wr_data_i;
      else                                       wr_val = {2{wr_data_i[BYTE_W-1:0]}};
   end

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic              hit;
      logic [WORD_W-1:0] word_q;
      assign hit = commit_i && (bulk || (wr_idx == ADDR_W'(w)));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q <= '1;
         end else if (hit) begin
            for (int l = 0; l < LANES; l++) begin
               if (lane_mask[l]) word_q[l*BYTE_W +: BYTE_W] <= wr_val[l*BYTE_W +: BYTE_W];
            end
         end
      end
      assign words[w] = word_q;
   end

   assign rd_word = words[rd_idx];

   always_comb begin
      if (wide_i)            rd_data_o = rd_word;
      else if (rd_addr_i[0]) rd_data_o = {rd_word[WORD_W-1:BYTE_W], BYTE_W'(0)};
      else                   rd_data_o = {rd_word[BYTE_W-1:0], BYTE_W'(0)};
   end

endmodule

// File: rtl/uwire_frame.sv
module uwire_frame
   import uwire_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              sk_rise_i,
   input  logic              sdi_i,
   input  logic              wide_i,
   input  logic              busy_i,
   input  logic [WORD_W-1:0] rd_word_i,
   output logic [ADDR_W:0]   rd_addr_o,
   output logic              commit_o,
   output uw_op_e            op_o,
   output logic [ADDR_W:0]   wr_addr_o,
   output logic [WORD_W-1:0] wr_data_o,
   output logic              sdo_o,
   output logic              sdo_oe_o
);
   localparam int AW8 = ADDR_W + 1;
   localparam int CW  = $clog2(WORD_W + 1);

   uw_st_e            st_q;
   uw_opc_e           opc_q;
   uw_op_e            pend_q;
   logic [CW-1:0]     cnt_q, alen, dlen;
   logic [ADDR_W:0]   addr_q, addr_nx;
   logic [WORD_W-1:0] data_q;
   logic [WORD_W:0]   out_q;
   logic              sel_q, wen_q, stat_q, rd_on_q;
   logic              cs_rise, cs_fall;
   logic [1:0]        sub;

   assign alen    = wide_i ? CW'(ADDR_W) : CW'(AW8);
   assign dlen    = wide_i ? CW'(WORD_W) : CW'(WORD_W / 2);
   assign addr_nx = {addr_q[ADDR_W-1:0], sdi_i};
   assign sub     = wide_i ? addr_nx[ADDR_W-1 -: 2] : addr_nx[ADDR_W -: 2];
   assign cs_rise = sel_i && !sel_q;
   assign cs_fall = !sel_i && sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         opc_q   <= OPC_SPECIAL;
         pend_q  <= OP_NONE;
         cnt_q   <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         out_q   <= '0;
         sel_q   <= 1'b0;
         wen_q   <= 1'b0;
         stat_q  <= 1'b0;
         rd_on_q <= 1'b0;
      end else begin
         sel_q <= sel_i;
         if (!sel_i) begin
            st_q    <= ST_IDLE;
            pend_q  <= OP_NONE;
            cnt_q   <= '0;
            stat_q  <= 1'b0;
            rd_on_q <= 1'b0;
         end else if (cs_rise && busy_i) begin
            stat_q <= 1'b1;
         end else if (stat_q) begin
            if (sk_rise_i && sdi_i && !busy_i) begin
               stat_q <= 1'b0;
               st_q   <= ST_DONE;
            end
         end else if (sk_rise_i && !busy_i) begin
            case (st_q)
               ST_IDLE: if (sdi_i) begin
                  st_q   <= ST_OPC;
                  cnt_q  <= '0;
                  addr_q <= '0;
               end
               ST_OPC: begin
                  opc_q <= uw_opc_e'({opc_q[0], sdi_i});
                  if (cnt_q == CW'(1)) begin
                     st_q  <= ST_ADR;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_ADR: begin
                  addr_q <= addr_nx;
                  if (cnt_q == alen - 1'b1) begin
                     cnt_q <= '0;
                     st_q  <= ST_DONE;
                     case (opc_q)
                        OPC_READ: begin
                           st_q    <= ST_READ;
                           rd_on_q <= 1'b1;
                           out_q   <= {1'b0, rd_word_i};
                        end
                        OPC_WRITE: st_q <= ST_DATA;
                        OPC_ERASE: pend_q <= OP_ERASE;
                        default: begin
                           case (sub)
                              SUB_UNLOCK:  wen_q  <= 1'b1;
                              SUB_LOCK:    wen_q  <= 1'b0;
                              SUB_CLRALL:  pend_q <= OP_CLRALL;
                              default:     st_q   <= ST_DATA;
                           endcase
                        end
                     endcase
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_DATA: begin
                  data_q <= {data_q[WORD_W-2:0], sdi_i};
                  if (cnt_q == dlen - 1'b1) begin
                     pend_q <= (opc_q == OPC_WRITE) ? OP_WRITE : OP_FILLALL;
                     st_q   <= ST_DONE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_READ: begin
                  if (cnt_q == dlen) begin
                     rd_on_q <= 1'b0;
                     st_q    <= ST_DONE;
                  end else begin
                     out_q <= {out_q[WORD_W-1:0], 1'b0};
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign rd_addr_o = addr_nx;
   assign commit_o  = cs_fall && (pend_q != OP_NONE) && wen_q && !busy_i;
   assign op_o      = pend_q;
   assign wr_addr_o = addr_q;
   assign wr_data_o = data_q;
   assign sdo_oe_o  = stat_q || rd_on_q;
   assign sdo_o     = sdo_oe_o && (stat_q ? !busy_i : out_q[WORD_W]);

   // R3: output released one clock after select drops
   assert_oe_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> !sdo_oe_o);
   // R9: status mode is entered only while a busy period is running
   assert_status_from_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q) |-> $past(busy_i));
   // R11: no read stream runs during a busy period
   assert_read_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_on_q |-> !busy_i);

endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
   import uwire_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int WORD_W     = 16,
   parameter int BUSY_SHORT = 4000,
   parameter int BUSY_LONG  = 8000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wide_org_i,
   input  logic sel_i,
   input  logic sclk_i,
   input  logic sdi_i,
   output logic sdo_o,
   output logic sdo_oe_o
);
   initial begin
      assert (ADDR_W >= 2) else $error("ADDR_W too small for special sub-commands");
      assert (WORD_W >= 4 && WORD_W % 2 == 0) else $error("WORD_W must be even and at least 4");
      assert (ADDR_W + 1 <= WORD_W) else $error("address longer than bit counter range");
      assert (BUSY_SHORT > 0 && BUSY_LONG > BUSY_SHORT) else $error("busy lengths inconsistent");
   end

   logic              wide_q, sclk_q, sk_rise;
   logic              commit, busy;
   uw_op_e            op;
   logic [ADDR_W:0]   rd_addr, wr_addr;
   logic [WORD_W-1:0] wr_data, rd_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wide_q <= wide_org_i;
         sclk_q <= 1'b0;
      end else begin
         sclk_q <= sclk_i;
      end
   end

   assign sk_rise = sel_i && sclk_i && !sclk_q;

   uwire_frame #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (sel_i),
      .sk_rise_i (sk_rise),
      .sdi_i     (sdi_i),
      .wide_i    (wide_q),
      .busy_i    (busy),
      .rd_word_i (rd_word),
      .rd_addr_o (rd_addr),
      .commit_o  (commit),
      .op_o      (op),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .sdo_o     (sdo_o),
      .sdo_oe_o  (sdo_oe_o)
   );

   uwire_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wide_i    (wide_q),
      .commit_i  (commit),
      .op_i      (op),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_word)
   );

   uwire_busy_timer #(.BUSY_SHORT(BUSY_SHORT), .BUSY_LONG(BUSY_LONG)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (commit),
      .long_i  ((op == OP_CLRALL) || (op == OP_FILLALL)),
      .busy_o  (busy)
   );

   // R9: every accepted store opens a busy period on the next cycle
   assert_commit_starts_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> busy);
   // R11: no store is accepted while busy
   assert_no_commit_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !commit);

endmodule

// File: tb/uwire_eeprom_bench.sv
module uwire_eeprom_bench;
   localparam int SHORT = 40;
   localparam int LONG  = 80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wide = 1'b1;
   logic sel = 1'b0;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   logic sdo, oe;
   int   n_chk = 0;
   int   n_fail = 0;

   always #2.5 clk = ~clk;

   uwire_eeprom #(.ADDR_W(6), .WORD_W(16), .BUSY_SHORT(SHORT), .BUSY_LONG(LONG)) u_uwire_eeprom (
      .clk(clk), .rst_n(rst_n), .wide_org_i(wide), .sel_i(sel),
      .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(oe)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic w);
      @(negedge clk); rst_n = 1'b0; wide = w; sel = 1'b0; sclk = 1'b0; sdi = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b);
      @(negedge clk); sdi = b;
      repeat (3) @(negedge clk); sclk = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b0;
   endtask

   task automatic shift(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
   endtask

   task automatic cs_up();
      @(negedge clk); sel = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic cs_down();
      @(negedge clk); sel = 1'b0; sclk = 1'b0;
   endtask

   task automatic wait_ready();
      repeat (LONG + 10) @(negedge clk);
   endtask

   // select high shortly after the store began, sampled 4 cycles after commit
   task automatic poll_begin();
      repeat (2) @(negedge clk); sel = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic cmd(input logic [1:0] opc, input logic [6:0] a, input int alen,
                      input logic [15:0] d, input int dlen);
      cs_up();
      clk_bit(1'b1);
      shift({30'd0, opc}, 2);
      shift({25'd0, a}, alen);
      if (dlen > 0) shift({16'd0, d}, dlen);
      cs_down();
   endtask

   task automatic rd(input logic [6:0] a, input int alen, input int dlen,
                     output logic [15:0] w, output logic fmt_ok);
      w = '0; fmt_ok = 1'b1;
      cs_up();
      clk_bit(1'b1);
      shift(32'b10, 2);
      shift({25'd0, a}, alen);
      if (!(oe === 1'b1 && sdo === 1'b0)) fmt_ok = 1'b0;
      for (int k = 0; k < dlen; k++) begin
         clk_bit(1'b0);
         if (oe !== 1'b1) fmt_ok = 1'b0;
         w = {w[14:0], sdo};
      end
      clk_bit(1'b0);
      if (oe !== 1'b0) fmt_ok = 1'b0;
      cs_down();
      repeat (3) @(negedge clk);
   endtask

   task automatic expect_word(input string tag, input logic [6:0] a, input int alen,
                              input int dlen, input logic [15:0] exp);
      logic [15:0] w;
      logic        ok;
      rd(a, alen, dlen, w, ok);
      check(tag, {16'd0, w}, {16'd0, exp});
      check({tag, " read framing"}, {31'd0, ok}, 32'd1);
   endtask

   task automatic t_reset();
      do_reset(1'b1);
      check("R1 oe after reset", {31'd0, oe}, 32'd0);
      expect_word("R1 array ones", 7'd5, 6, 16, 16'hFFFF);
      cmd(2'b01, 7'd3, 6, 16'h1234, 16);
      poll_begin();
      check("R4 no busy while locked", {31'd0, oe}, 32'd0);
      cs_down(); wait_ready();
      expect_word("R4 locked write dropped", 7'd3, 6, 16, 16'hFFFF);
   endtask

   task automatic t_write();
      cmd(2'b00, 7'h30, 6, 16'h0, 0);
      repeat (4) @(negedge clk);
      cmd(2'b01, 7'd3, 6, 16'hA5C3, 16);
      poll_begin();
      check("R9 busy flag", {30'd0, oe, sdo}, 32'b10);
      repeat (45) @(negedge clk);
      check("R9 ready after short period", {30'd0, oe, sdo}, 32'b11);
      clk_bit(1'b1);
      check("R10 dummy one releases", {31'd0, oe}, 32'd0);
      cs_down(); repeat (4) @(negedge clk);
      expect_word("R6 write data", 7'd3, 6, 16, 16'hA5C3);
      expect_word("R6 neighbour untouched", 7'd4, 6, 16, 16'hFFFF);
   endtask

   task automatic t_frame();
      cs_up();
      clk_bit(1'b0); clk_bit(1'b0);
      clk_bit(1'b1); shift(32'b01, 2); shift(32'd10, 6); shift(32'h1357, 16);
      cs_down(); wait_ready();
      expect_word("R2 leading zeros skipped", 7'd10, 6, 16, 16'h1357);
      cs_up();
      clk_bit(1'b1); shift(32'b01, 2); shift(32'd11, 6); shift(32'h2AB, 10);
      cs_down();
      poll_begin();
      check("R6 short frame no busy", {31'd0, oe}, 32'd0);
      cs_down(); wait_ready();
      expect_word("R6 short frame dropped", 7'd11, 6, 16, 16'hFFFF);
   endtask

   task automatic t_erase();
      cmd(2'b11, 7'd3, 6, 16'h0, 0); wait_ready();
      expect_word("R7 erase to ones", 7'd3, 6, 16, 16'hFFFF);
   endtask

   task automatic t_busy();
      cmd(2'b01, 7'd20, 6, 16'hBEEF, 16);
      poll_begin();
      clk_bit(1'b1);
      check("R10 dummy one while busy kept", {30'd0, oe, sdo}, 32'b10);
      cs_down();
      cmd(2'b01, 7'd21, 6, 16'h1111, 16);
      wait_ready();
      expect_word("R11 frame during busy ignored", 7'd21, 6, 16, 16'hFFFF);
      expect_word("R11 first write kept", 7'd20, 6, 16, 16'hBEEF);
   endtask

   task automatic t_lock();
      cmd(2'b00, 7'h00, 6, 16'h0, 0); repeat (4) @(negedge clk);
      cmd(2'b01, 7'd20, 6, 16'h0000, 16); wait_ready();
      expect_word("R5 lock blocks write", 7'd20, 6, 16, 16'hBEEF);
      expect_word("R13 read while locked", 7'd10, 6, 16, 16'h1357);
   endtask

   task automatic t_bulk();
      cmd(2'b00, 7'h30, 6, 16'h0, 0); repeat (4) @(negedge clk);
      cmd(2'b00, 7'h10, 6, 16'h0F0F, 16);
      poll_begin();
      repeat (50) @(negedge clk);
      check("R8 long busy beyond short", {30'd0, oe, sdo}, 32'b10);
      repeat (40) @(negedge clk);
      check("R8 long busy ends", {30'd0, oe, sdo}, 32'b11);
      cs_down(); repeat (4) @(negedge clk);
      expect_word("R8 fill first", 7'd0, 6, 16, 16'h0F0F);
      expect_word("R8 fill last", 7'd63, 6, 16, 16'h0F0F);
      cmd(2'b00, 7'h20, 6, 16'h0, 0); wait_ready();
      expect_word("R8 clear all", 7'd37, 6, 16, 16'hFFFF);
   endtask

   task automatic t_bytes();
      do_reset(1'b0);
      expect_word("R12 byte read after reset", 7'd5, 7, 8, 16'h00FF);
      cmd(2'b00, 7'h60, 7, 16'h0, 0); repeat (4) @(negedge clk);
      cmd(2'b01, 7'd9, 7, 16'h003C, 8); wait_ready();
      cmd(2'b01, 7'd8, 7, 16'h00A7, 8); wait_ready();
      expect_word("R12 upper byte", 7'd9, 7, 8, 16'h003C);
      expect_word("R12 lower byte", 7'd8, 7, 8, 16'h00A7);
      expect_word("R12 other word", 7'd10, 7, 8, 16'h00FF);
      cmd(2'b11, 7'd9, 7, 16'h0, 0); wait_ready();
      expect_word("R12 erase one byte", 7'd9, 7, 8, 16'h00FF);
      expect_word("R12 partner byte kept", 7'd8, 7, 8, 16'h00A7);
   endtask

   initial begin
      t_reset();
      t_write();
      t_frame();
      t_erase();
      t_busy();
      t_lock();
      t_bulk();
      t_bytes();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule